// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits after a page-table search has found a matching entry. It takes the second doubleword of that entry, the two key bits of the segment that maps the address, the privilege state of the processor and the kind of access. One cycle after an input strobe it returns the read, write and execute rights, the storage attributes, the real address and page size, a fault flag, and any byte stores needed to set the referenced and changed bits in memory.

Rights come from a 4-bit protection code. The code is built from the two protection bits of the entry, a key bit chosen by privilege, and the high protection bit. A table then turns the code into rights. The referenced and changed bits are updated through single-byte stores, so the rest of the entry is never rewritten. A configurable override page bypasses the table for supervisor accesses and grants full access.

The caller supplies the page size code, because the page-table search works it out. Searching the page table and looking up segments are outside this block.

Top module: `page_perm_checker`

## Requirements
- R1: While rst_n is low at a clock edge, every output register goes to zero. This includes out_valid, the rights, fault and both byte-store enables.
- R2: Results appear on the clock edge after the edge that samples in_valid=1, with out_valid=1. After an edge with in_valid=0, out_valid, rset_we and cset_we are all 0.
- R3: The protection code is {pte_w1[63], key, pte_w1[1:0]}. Bit 63 is the high protection bit and bits 1:0 are the low protection bits. key is seg_kp when problem=1 and seg_ks when problem=0.
- R4: Codes 0, 1, 2 and 6 grant read and write. Codes 3, 5, 7 and 10 grant read only. Every other code grants neither.
- R5: ex_ok is 1 when the no-execute bit pte_w1[2] is 0, or when nx_override=1 and problem=0. Otherwise ex_ok is 0.
- R6: fault is 1 when read is denied, or when acc_wr=1 and write is denied.
- R7: When read is granted and the referenced bit pte_w1[8] is 0, rset_we=1. rset_byte then holds pte_w1[15:8] with bit 0 set, which is byte 6 of the doubleword in big-endian byte order.
- R8: When acc_wr=1, write is granted and the changed bit pte_w1[7] is 0, cset_we=1. cset_byte then holds pte_w1[7:0] with bit 7 set, which is byte 7 in big-endian byte order.
- R9: The override applies when ov_en=1, problem=0 and ea[EA_W-1:12] equals ov_ea_pg. It grants read, write and execute with no fault and no byte stores. It reports wimg=4'b0010 (the M attribute), psz_out=0, and pa={ov_pa_pg, ea[11:0]}.
- R10: Outside the override, wimg equals pte_w1[6:3]. Page size codes 0, 1 and 2 select 12, 16 and 24 offset bits, and code 3 is treated as 0. psz_out carries the resulting code. pa takes pte_w1[RA_W-1:0] above the offset and ea below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| ea | input | EA_W | Effective address |
| pte_w1 | input | 64 | Second doubleword of the matched entry |
| seg_ks | input | 1 | Segment supervisor key |
| seg_kp | input | 1 | Segment problem-state key |
| problem | input | 1 | 1 = problem (user) state |
| acc_wr | input | 1 | 1 = write access |
| nx_override | input | 1 | Forces execute on in supervisor state |
| psz_in | input | 2 | Page size code of the entry |
| ov_en | input | 1 | Override page enable |
| ov_ea_pg | input | EA_W-12 | Override effective page number |
| ov_pa_pg | input | RA_W-12 | Override real page number |
| out_valid | output | 1 | Result valid |
| rd_ok | output | 1 | Read permitted |
| wr_ok | output | 1 | Write permitted |
| ex_ok | output | 1 | Execute permitted |
| fault | output | 1 | Protection fault |
| wimg | output | 4 | Storage attributes |
| pa | output | RA_W | Real address |
| psz_out | output | 2 | Page size code |
| rset_we | output | 1 | Store byte 6 |
| rset_byte | output | 8 | Data for byte 6 |
| cset_we | output | 1 | Store byte 7 |
| cset_byte | output | 8 | Data for byte 7 |

## Verification
The bench builds the block with EA_W=24 and RA_W=24. This keeps page numbers short, so override matches and misses are easy to place, and a 16 MB page covers the whole real address. Every combination of the three protection bits, both key bits, privilege, access type, referenced, changed, no-execute and execute-override bits is swept, which reaches all sixteen protection codes under both keys. The real-address composition is checked for each page size code, including the reserved one. The override is checked against each of its three miss conditions.

// File: rtl/pgperm_pkg.sv
// Package: shared constants and types for the page permission checker.
// Assumes the second entry doubleword uses LSB-0 bit numbering.
package pgperm_pkg;
    localparam int DW      = 64;
    localparam int BIT_PP0 = 63;
    localparam int BIT_REF = 8;
    localparam int BIT_CHG = 7;
    localparam int BIT_NX  = 2;
    localparam int ATTR_LO = 3;
    localparam int BASE_SH = 12;

    typedef enum logic [1:0] {
        PSZ_4K  = 2'd0,
        PSZ_64K = 2'd1,
        PSZ_16M = 2'd2,
        PSZ_RSV = 2'd3
    } psz_e;

    localparam logic [3:0] ATTR_M = 4'b0010;

    // Offset width in bits for a page size code
    function automatic int psz_bits(input logic [1:0] code);
        case (code)
            PSZ_64K: psz_bits = 16;
            PSZ_16M: psz_bits = 24;
            default: psz_bits = 12;
        endcase
    endfunction
endpackage

// File: rtl/pgperm_code_decode.sv
// Module: turns the 4-bit protection code into read/write rights.
// Assumes the code is {pp0, key, pp[1:0]}.
module pgperm_code_decode (
    input  logic [1:0] pp,
    input  logic       pp0,
    input  logic       key,
    output logic [3:0] code,
    output logic       rd,
    output logic       wr
);
    assign code = {pp0, key, pp};

    // Table lookup of rights per code
    always_comb begin
        case (code)
            4'd0, 4'd1, 4'd2, 4'd6: begin rd = 1'b1; wr = 1'b1; end
            4'd3, 4'd5, 4'd7, 4'd10: begin rd = 1'b1; wr = 1'b0; end
            default: begin rd = 1'b0; wr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pgperm_rc_update.sv
// Module: builds the single-byte stores that set referenced/changed bits.
// Assumes the referenced bit is bit 0 of byte 6 and the changed bit is
// bit 7 of byte 7 (big-endian byte order within the doubleword).
module pgperm_rc_update
    import pgperm_pkg::*;
(
    input  logic [15:0] lo16,
    input  logic        rd,
    input  logic        wr,
    input  logic        acc_wr,
    output logic        r_we,
    output logic [7:0]  r_byte,
    output logic        c_we,
    output logic [7:0]  c_byte
);
    // Decide which bytes need storing and their new contents
    always_comb begin
        r_we   = rd && !lo16[BIT_REF];
        r_byte = lo16[15:8] | 8'h01;
        c_we   = acc_wr && wr && !lo16[BIT_CHG];
        c_byte = lo16[7:0] | 8'h80;
    end
endmodule

// File: rtl/pgperm_addr.sv
// Module: real address composition and override page match.
// Assumes RA_W >= 24 so the largest page offset fits in the real address.
module pgperm_addr
    import pgperm_pkg::*;
#(
    parameter int EA_W = 64,
    parameter int RA_W = 60
) (
    input  logic [EA_W-1:0]    ea,
    input  logic [RA_W-1:0]    rpn_field,
    input  logic [1:0]         psz_in,
    input  logic               ov_en,
    input  logic               problem,
    input  logic [EA_W-13:0]   ov_ea_pg,
    input  logic [RA_W-13:0]   ov_pa_pg,
    output logic               ov_hit,
    output logic [RA_W-1:0]    pa_tab,
    output logic [RA_W-1:0]    pa_ov,
    output logic [1:0]         psz_out
);
    localparam int MW = (EA_W < RA_W) ? EA_W : RA_W;

    logic [RA_W-1:0] ofs_mask;
    logic [RA_W-1:0] ea_ext;
    int              nbits;

    // Pick the offset width from the size code
    always_comb begin
        nbits   = psz_bits(psz_in);
        psz_out = (psz_in == PSZ_RSV) ? PSZ_4K : psz_in;
    end

    // One mask bit per address bit: set below the offset width
    for (genvar i = 0; i < RA_W; i++) begin : g_mask
        assign ofs_mask[i] = (i < nbits);
    end

    // Zero-extend or truncate the effective address to real width
    always_comb begin
        ea_ext = '0;
        ea_ext[MW-1:0] = ea[MW-1:0];
    end

    // Table path address, override path address and override match
    always_comb begin
        pa_tab = (rpn_field & ~ofs_mask) | (ea_ext & ofs_mask);
        pa_ov  = {ov_pa_pg, ea[BASE_SH-1:0]};
        ov_hit = ov_en && !problem && (ea[EA_W-1:BASE_SH] == ov_ea_pg);
    end
endmodule

// File: rtl/page_perm_checker.sv
// Module: top of the page permission checker. Combines the code decode,
// byte-store builder and address logic, then registers one result per
// input strobe. Assumes the caller has already found the entry.
module page_perm_checker
    import pgperm_pkg::*;
#(
    parameter int EA_W = 64,
    parameter int RA_W = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [EA_W-1:0]  ea,
    input  logic [63:0]      pte_w1,
    input  logic             seg_ks,
    input  logic             seg_kp,
    input  logic             problem,
    input  logic             acc_wr,
    input  logic             nx_override,
    input  logic [1:0]       psz_in,
    input  logic             ov_en,
    input  logic [EA_W-13:0] ov_ea_pg,
    input  logic [RA_W-13:0] ov_pa_pg,
    output logic             out_valid,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             ex_ok,
    output logic             fault,
    output logic [3:0]       wimg,
    output logic [RA_W-1:0]  pa,
    output logic [1:0]       psz_out,
    output logic             rset_we,
    output logic [7:0]       rset_byte,
    output logic             cset_we,
    output logic [7:0]       cset_byte
);
    logic [3:0]      code;
    logic            t_rd, t_wr, t_ex, t_fault, key;
    logic            r_we, c_we, ov_hit;
    logic [7:0]      r_byte, c_byte;
    logic [RA_W-1:0] pa_tab, pa_ov;
    logic [1:0]      psz_tab;

    logic            n_rd, n_wr, n_ex, n_fault, n_rwe, n_cwe;
    logic [3:0]      n_wimg;
    logic [RA_W-1:0] n_pa;
    logic [1:0]      n_psz;

    // Key follows privilege
    assign key = problem ? seg_kp : seg_ks;

    pgperm_code_decode u_dec (
        .pp   (pte_w1[1:0]),
        .pp0  (pte_w1[BIT_PP0]),
        .key  (key),
        .code (code),
        .rd   (t_rd),
        .wr   (t_wr)
    );

    pgperm_rc_update u_rc (
        .lo16   (pte_w1[15:0]),
        .rd     (t_rd),
        .wr     (t_wr),
        .acc_wr (acc_wr),
        .r_we   (r_we),
        .r_byte (r_byte),
        .c_we   (c_we),
        .c_byte (c_byte)
    );

    pgperm_addr #(.EA_W(EA_W), .RA_W(RA_W)) u_addr (
        .ea        (ea),
        .rpn_field (pte_w1[RA_W-1:0]),
        .psz_in    (psz_in),
        .ov_en     (ov_en),
        .problem   (problem),
        .ov_ea_pg  (ov_ea_pg),
        .ov_pa_pg  (ov_pa_pg),
        .ov_hit    (ov_hit),
        .pa_tab    (pa_tab),
        .pa_ov     (pa_ov),
        .psz_out   (psz_tab)
    );

    // Execute right and fault for the table path
    always_comb begin
        t_ex    = !pte_w1[BIT_NX] || (nx_override && !problem);
        t_fault = !t_rd || (acc_wr && !t_wr);
    end

    // Select between override and table results
    always_comb begin
        if (ov_hit) begin
            n_rd = 1'b1; n_wr = 1'b1; n_ex = 1'b1; n_fault = 1'b0;
            n_rwe = 1'b0; n_cwe = 1'b0;
            n_wimg = ATTR_M; n_pa = pa_ov; n_psz = PSZ_4K;
        end else begin
            n_rd = t_rd; n_wr = t_wr; n_ex = t_ex; n_fault = t_fault;
            n_rwe = r_we; n_cwe = c_we;
            n_wimg = pte_w1[ATTR_LO+3:ATTR_LO]; n_pa = pa_tab; n_psz = psz_tab;
        end
    end

    // Valid and store-enable register: pulse for one cycle per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rset_we   <= 1'b0;
            cset_we   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            rset_we   <= in_valid && n_rwe;
            cset_we   <= in_valid && n_cwe;
        end
    end

    // Result register: captured on each strobe, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ok <= 1'b0; wr_ok <= 1'b0; ex_ok <= 1'b0; fault <= 1'b0;
            wimg <= '0; pa <= '0; psz_out <= '0;
            rset_byte <= '0; cset_byte <= '0;
        end else if (in_valid) begin
            rd_ok <= n_rd; wr_ok <= n_wr; ex_ok <= n_ex; fault <= n_fault;
            wimg <= n_wimg; pa <= n_pa; psz_out <= n_psz;
            rset_byte <= r_byte; cset_byte <= c_byte;
        end
    end
endmodule

// File: rtl/pgperm_checker.sv
// Module: property checker for page_perm_checker, bound to every instance.
// Assumes the same parameters as the checked instance.
module pgperm_checker #(
    parameter int EA_W = 64,
    parameter int RA_W = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [EA_W-1:0]  ea,
    input logic [63:0]      pte_w1,
    input logic             problem,
    input logic             acc_wr,
    input logic             ov_en,
    input logic [EA_W-13:0] ov_ea_pg,
    input logic             out_valid,
    input logic             rd_ok,
    input logic             wr_ok,
    input logic             ex_ok,
    input logic             fault,
    input logic [3:0]       wimg,
    input logic             rset_we,
    input logic [7:0]       rset_byte,
    input logic             cset_we,
    input logic [7:0]       cset_byte
);
    logic ov_req;
    assign ov_req = in_valid && ov_en && !problem && (ea[EA_W-1:12] == ov_ea_pg);

    p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !rset_we && !cset_we));
    p_write_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wr_ok) |-> rd_ok);
    p_exec_clear_nx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pte_w1[2]) |=> ex_ok);
    p_fault_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_wr) |=> (fault == !(rd_ok && wr_ok)));
    p_fault_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_wr) |=> (fault == !rd_ok));
    p_ref_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rset_we |-> (rd_ok && rset_byte[0]));
    p_chg_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cset_we |-> (wr_ok && cset_byte[7]));
    p_override_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ov_req |=> (rd_ok && wr_ok && ex_ok && !fault && wimg == 4'b0010
                    && !rset_we && !cset_we));
endmodule

bind page_perm_checker pgperm_checker #(.EA_W(EA_W), .RA_W(RA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ea        (ea),
    .pte_w1    (pte_w1),
    .problem   (problem),
    .acc_wr    (acc_wr),
    .ov_en     (ov_en),
    .ov_ea_pg  (ov_ea_pg),
    .out_valid (out_valid),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .ex_ok     (ex_ok),
    .fault     (fault),
    .wimg      (wimg),
    .rset_we   (rset_we),
    .rset_byte (rset_byte),
    .cset_we   (cset_we),
    .cset_byte (cset_byte)
);

// File: tb/page_perm_checker_test.sv
// Bench: sweeps all protection inputs, page sizes and override cases.
module page_perm_checker_test;
    localparam int EA_W = 24;
    localparam int RA_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [EA_W-1:0]  ea = '0;
    logic [63:0]      pte_w1 = '0;
    logic             seg_ks = 1'b0, seg_kp = 1'b0, problem = 1'b0;
    logic             acc_wr = 1'b0, nx_override = 1'b0, ov_en = 1'b0;
    logic [1:0]       psz_in = '0;
    logic [EA_W-13:0] ov_ea_pg = '0;
    logic [RA_W-13:0] ov_pa_pg = '0;
    logic             out_valid, rd_ok, wr_ok, ex_ok, fault, rset_we, cset_we;
    logic [3:0]       wimg;
    logic [RA_W-1:0]  pa;
    logic [1:0]       psz_out;
    logic [7:0]       rset_byte, cset_byte;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    page_perm_checker #(.EA_W(EA_W), .RA_W(RA_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ea(ea), .pte_w1(pte_w1),
        .seg_ks(seg_ks), .seg_kp(seg_kp), .problem(problem), .acc_wr(acc_wr),
        .nx_override(nx_override), .psz_in(psz_in), .ov_en(ov_en),
        .ov_ea_pg(ov_ea_pg), .ov_pa_pg(ov_pa_pg), .out_valid(out_valid),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .ex_ok(ex_ok), .fault(fault), .wimg(wimg),
        .pa(pa), .psz_out(psz_out), .rset_we(rset_we), .rset_byte(rset_byte),
        .cset_we(cset_we), .cset_byte(cset_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request, then sample after the capturing edge
    task automatic issue();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] code;
        logic       k, erd, ewr, eex;
        logic [RA_W-1:0] msk;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 rights", {rd_ok, wr_ok, ex_ok, fault}, 0);
        chk("R1 stores", {rset_we, cset_we}, 0);
        rst_n = 1'b1;

        // R3 R4 R5 R6 R7 R8: full sweep of protection inputs
        for (int v = 0; v < 2048; v++) begin
            pte_w1 = 64'h0000_00AB_CDE0_0000 ^ {56'd0, v[10:3], 8'd0};
            pte_w1[1:0] = v[1:0];
            pte_w1[63]  = v[2];
            seg_ks      = v[3];
            seg_kp      = v[4];
            problem     = v[5];
            acc_wr      = v[6];
            pte_w1[8]   = v[7];
            pte_w1[7]   = v[8];
            pte_w1[2]   = v[9];
            nx_override = v[10];
            pte_w1[6:3] = v[3:0] ^ v[10:7];
            ea = 24'h123456 ^ 24'(v);
            psz_in = 2'd0;
            ov_en = 1'b0;
            issue();
            k    = problem ? seg_kp : seg_ks;
            code = {pte_w1[63], k, pte_w1[1:0]};
            ewr  = (code == 0) || (code == 1) || (code == 2) || (code == 6);
            erd  = ewr || (code == 3) || (code == 5) || (code == 7) || (code == 10);
            eex  = !pte_w1[2] || (nx_override && !problem);
            chk("R2 out_valid", out_valid, 1);
            chk("R3/R4 rights", {rd_ok, wr_ok}, {erd, ewr});
            chk("R5 exec", ex_ok, eex);
            chk("R6 fault", fault, !erd || (acc_wr && !ewr));
            chk("R7 ref store", {rset_we, rset_byte}, {erd && !pte_w1[8], pte_w1[15:9], 1'b1});
            chk("R8 chg store", {cset_we, cset_byte},
                {acc_wr && ewr && !pte_w1[7], 1'b1, pte_w1[6:0]});
            chk("R10 wimg", wimg, pte_w1[6:3]);
            @(negedge clk);
            chk("R2 idle", {out_valid, rset_we, cset_we}, 0);
        end

        // R10: address composition for each size code
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 3; j++) begin
                psz_in = 2'(s);
                pte_w1 = 64'h0 | (24'hF0F0F0 ^ 24'(j * 24'h333333));
                pte_w1[1:0] = 2'd0;
                ea = 24'hA5A5A5 + 24'(j * 24'h010101);
                problem = 1'b0; seg_ks = 1'b0; ov_en = 1'b0;
                issue();
                msk = (s == 1) ? 24'h00FFFF : (s == 2) ? 24'hFFFFFF : 24'h000FFF;
                chk("R10 pa", pa, (pte_w1[23:0] & ~msk) | (ea & msk));
                chk("R10 psz", psz_out, (s == 3) ? 0 : s);
            end
        end

        // R9: override hit in supervisor state, with denying entry
        pte_w1 = 64'h0000_0000_0000_0107;  // code 3, nx set, R set
        pte_w1[63] = 1'b1;                 // code 11: no rights
        psz_in = 2'd2;
        ov_en = 1'b1; ov_ea_pg = 12'h5A5; ov_pa_pg = 12'h3C3;
        ea = 24'h5A5ABC; problem = 1'b0; acc_wr = 1'b1;
        issue();
        chk("R9 override rights", {rd_ok, wr_ok, ex_ok, fault}, 4'b1110);
        chk("R9 override attr", wimg, 4'b0010);
        chk("R9 override pa", pa, 24'h3C3ABC);
        chk("R9 override psz", psz_out, 0);
        chk("R9 override stores", {rset_we, cset_we}, 0);
        // R9: misses by problem state, by page and by disable
        problem = 1'b1; seg_kp = 1'b0;
        issue();
        chk("R9 miss problem", {rd_ok, fault}, 2'b01);
        problem = 1'b0; ea = 24'h5A6ABC;
        issue();
        chk("R9 miss page", {rd_ok, fault}, 2'b01);
        ea = 24'h5A5ABC; ov_en = 1'b0;
        issue();
        chk("R9 miss disabled", {rd_ok, fault}, 2'b01);

        // R1: reset clears a valid result
        issue();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset after use", {out_valid, rd_ok, wr_ok, ex_ok, fault}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule